// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block serves single-word read and write requests against a small dynamic memory array that lives inside it. The array is organised as rows of supercells (4 rows of 4 supercells of 8 bits by default). Each access is broken into strobe steps that are visible at the ports. A row step opens the addressed row by copying it into a row buffer. A column step then moves one supercell between that buffer and the data path. Both steps share one narrow address bus: it carries the row index during the row step and the column index during the column step.

The controller keeps the last opened row in the buffer. Another access to that same row skips the row step and costs only a column step. An access to a different row first writes the buffer back to the array, then opens the new row. Writes change the buffered copy only, so write-back is what keeps stored data correct. A free-running interval timer raises a refresh request. The request is taken only between accesses. It closes any open row and then runs a row-only refresh cycle on the next row of a rotating refresh pointer.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `ras_strobe`, `cas_strobe` and `refresh_cycle` are 0, and no row is open, so the first access costs a row step.
- R2: An access while no row is open gives one cycle with `ras_strobe`=1 and `dram_addr`=row, then one cycle with `cas_strobe`=1 and `dram_addr`=column. `rsp_valid` is high 2 clock edges after the accepting edge.
- R3: An access to the open row gives no row strobe, only one column-strobe cycle with `dram_addr`=column. `rsp_valid` is high 1 edge after the accepting edge.
- R4: An access to a row other than the open one spends one cycle with no strobe (write-back), then a row step and a column step. `rsp_valid` is high 3 edges after the accepting edge.
- R5: A read returns in `rsp_rdata` the last value written to that row and column. A write returns its own data. A write leaves the other supercells of the row unchanged.
- R6: Data written while a row is open stays readable after that row is closed, whether a page miss or a refresh closed it.
- R7: When no row is open and no request is pending, refresh cycles come exactly every REFRESH_INTERVAL cycles. A refresh cycle has `refresh_cycle`=1 and `ras_strobe`=1 with `dram_addr` set to the refresh pointer. The pointer starts at 0 and steps by one, wrapping, on each refresh.
- R8: A refresh is started only from the idle state, never during an access. It closes the open row, so the next access costs a full row step. While a refresh is due, `req_ready` is 0. A refresh cycle never carries a column strobe.
- R9: `ras_strobe` and `cas_strobe` are never high together. `rsp_valid` is a single-cycle pulse, given exactly once for each accepted request.
- R10: A due refresh is served within 6 cycles of its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | 2 | Row index of the request |
| req_col | input | 2 | Column index of the request |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted on this edge when valid |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, or the written data for a write |
| ras_strobe | output | 1 | Row step (or refresh) in progress |
| cas_strobe | output | 1 | Column step in progress |
| dram_addr | output | 2 | Multiplexed row / column / refresh row index |
| refresh_cycle | output | 1 | Current cycle is a refresh |

## Verification
The request stream hits the three page states in turn. A cold access, a run of same-row hits and row conflicts are told apart by the response latency and by the number of row strobes each access causes. Reading back a neighbour supercell after a write shows whether the column merge into the buffer is confined to one supercell. Returning to a row after a conflict, and again after a refresh, shows whether the write-back happened. Idle stretches across several refreshes test the refresh period, the pointer rotation and the forced closing of the open row.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WBACK = 3'd1,
        ST_ROW = 3'd2,
        ST_COL = 3'd3,
        ST_RFSH = 3'd4
    } ctrl_state_e;

endpackage

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int ROWS   = 4,
    parameter int LINE_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(ROWS)-1:0] rd_row,
    output logic [LINE_W-1:0]       rd_line,
    input  logic                    wr_en,
    input  logic [$clog2(ROWS)-1:0] wr_row,
    input  logic [LINE_W-1:0]       wr_line
);

    logic [LINE_W-1:0] mem_q [ROWS];

    always_comb begin
        rd_line = mem_q[rd_row];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem_q[r] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_row] <= wr_line;
        end
    end

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int INTERVAL = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);

    localparam int CNT_W = $clog2(INTERVAL);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic tick;

    always_comb begin
        tmr_d = tmr_q;
        tick  = (tmr_q.cnt == CNT_W'(INTERVAL - 1));
        if (tick) begin
            tmr_d.cnt  = '0;
            tmr_d.pend = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
            if (ack) begin
                tmr_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign pending = tmr_q.pend;

    AST_ACK_ONLY_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> tmr_q.pend); // R8

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int ROWS             = 4,
    parameter int COLS             = 4,
    parameter int WORD_W           = 8,
    parameter int REFRESH_INTERVAL = 200
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          req_valid,
    input  logic                                          req_write,
    input  logic [$clog2(ROWS)-1:0]                       req_row,
    input  logic [$clog2(COLS)-1:0]                       req_col,
    input  logic [WORD_W-1:0]                             req_wdata,
    output logic                                          req_ready,
    output logic                                          rsp_valid,
    output logic [WORD_W-1:0]                             rsp_rdata,
    output logic                                          ras_strobe,
    output logic                                          cas_strobe,
    output logic [(ROWS > COLS ? $clog2(ROWS) : $clog2(COLS))-1:0] dram_addr,
    output logic                                          refresh_cycle
);

    localparam int RW           = $clog2(ROWS);
    localparam int CW           = $clog2(COLS);
    localparam int AW           = (RW > CW) ? RW : CW;
    localparam int LINE_W       = COLS * WORD_W;
    localparam int REF_WAIT_MAX = 6;

    typedef struct packed {
        ctrl_state_e       st;
        logic              open;
        logic [RW-1:0]     open_row;
        logic [RW-1:0]     row;
        logic [CW-1:0]     col;
        logic              wr;
        logic [WORD_W-1:0] wdata;
        logic              to_rfsh;
        logic [RW-1:0]     rfsh_ptr;
        logic [LINE_W-1:0] rowbuf;
        logic              rsp;
        logic [WORD_W-1:0] rdata;
    } ctrl_t;

    ctrl_t             ctl_d, ctl_q;
    logic              rfsh_pend;
    logic              rfsh_ack;
    logic              wb_en;
    logic [LINE_W-1:0] arr_line;

    dram_cell_array #(
        .ROWS   (ROWS),
        .LINE_W (LINE_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_row  (ctl_q.row),
        .rd_line (arr_line),
        .wr_en   (wb_en),
        .wr_row  (ctl_q.open_row),
        .wr_line (ctl_q.rowbuf)
    );

    dram_refresh_timer #(
        .INTERVAL (REFRESH_INTERVAL)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (rfsh_ack),
        .pending (rfsh_pend)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.rsp     = 1'b0;
        ras_strobe    = 1'b0;
        cas_strobe    = 1'b0;
        refresh_cycle = 1'b0;
        rfsh_ack      = 1'b0;
        wb_en         = 1'b0;
        dram_addr     = '0;
        req_ready     = (ctl_q.st == ST_IDLE) && !rfsh_pend;
        case (ctl_q.st)
            ST_IDLE: begin
                if (rfsh_pend) begin
                    ctl_d.to_rfsh = 1'b1;
                    ctl_d.st      = ctl_q.open ? ST_WBACK : ST_RFSH;
                end else if (req_valid) begin
                    ctl_d.to_rfsh = 1'b0;
                    ctl_d.row     = req_row;
                    ctl_d.col     = req_col;
                    ctl_d.wr      = req_write;
                    ctl_d.wdata   = req_wdata;
                    if (ctl_q.open && (ctl_q.open_row == req_row)) begin
                        ctl_d.st = ST_COL;
                    end else if (ctl_q.open) begin
                        ctl_d.st = ST_WBACK;
                    end else begin
                        ctl_d.st = ST_ROW;
                    end
                end
            end
            ST_WBACK: begin
                wb_en      = 1'b1;
                ctl_d.open = 1'b0;
                ctl_d.st   = ctl_q.to_rfsh ? ST_RFSH : ST_ROW;
            end
            ST_ROW: begin
                ras_strobe     = 1'b1;
                dram_addr      = AW'(ctl_q.row);
                ctl_d.rowbuf   = arr_line;
                ctl_d.open     = 1'b1;
                ctl_d.open_row = ctl_q.row;
                ctl_d.st       = ST_COL;
            end
            ST_COL: begin
                cas_strobe = 1'b1;
                dram_addr  = AW'(ctl_q.col);
                if (ctl_q.wr) begin
                    ctl_d.rowbuf[int'(ctl_q.col)*WORD_W +: WORD_W] = ctl_q.wdata;
                    ctl_d.rdata = ctl_q.wdata;
                end else begin
                    ctl_d.rdata = ctl_q.rowbuf[int'(ctl_q.col)*WORD_W +: WORD_W];
                end
                ctl_d.rsp = 1'b1;
                ctl_d.st  = ST_IDLE;
            end
            ST_RFSH: begin
                ras_strobe     = 1'b1;
                refresh_cycle  = 1'b1;
                rfsh_ack       = 1'b1;
                dram_addr      = AW'(ctl_q.rfsh_ptr);
                ctl_d.rfsh_ptr = ctl_q.rfsh_ptr + 1'b1;
                ctl_d.st       = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid = ctl_q.rsp;
    assign rsp_rdata = ctl_q.rdata;

    // cycles a due refresh has waited
    logic [3:0] wait_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !rfsh_pend || rfsh_ack) begin
            wait_cnt_q <= '0;
        end else begin
            wait_cnt_q <= wait_cnt_q + 1'b1;
        end
    end

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ras_strobe && cas_strobe)); // R9
    AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9
    AST_COL_NEEDS_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        cas_strobe |-> ctl_q.open); // R3
    AST_ROW_STROBE_OPENS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_strobe && !refresh_cycle) |=> (ctl_q.open && (AW'(ctl_q.open_row) == $past(dram_addr)))); // R2
    AST_REFRESH_ROW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_cycle |-> (!ctl_q.open && !cas_strobe)); // R8
    AST_REFRESH_BOUNDED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt_q <= 4'(REF_WAIT_MAX)); // R10

endmodule

// File: tb/dram_page_ctrl_tb.sv
module dram_page_ctrl_tb;

    localparam int INTERVAL = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [1:0] req_row = '0;
    logic [1:0] req_col = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ready;
    logic       rsp_valid;
    logic [7:0] rsp_rdata;
    logic       ras_strobe;
    logic       cas_strobe;
    logic [1:0] dram_addr;
    logic       refresh_cycle;

    always #5 clk = ~clk;

    dram_page_ctrl #(
        .ROWS (4), .COLS (4), .WORD_W (8), .REFRESH_INTERVAL (INTERVAL)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
        .req_row (req_row), .req_col (req_col), .req_wdata (req_wdata),
        .req_ready (req_ready), .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .ras_strobe (ras_strobe), .cas_strobe (cas_strobe), .dram_addr (dram_addr),
        .refresh_cycle (refresh_cycle)
    );

    typedef struct {
        logic [7:0] data;
        int         lat;
        int         acc;
        int         ras0;
        int         nras;
        string      tag;
    } exp_t;

    exp_t  sb[$];
    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    ras_cnt = 0;
    int    cur_row = 0;
    int    cur_col = 0;
    int    exp_ptr = 0;
    int    rf_n = 0;
    int    rf_last = 0;
    int    rf_period = 0;
    bit    mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: strobes, refresh and scoreboard pops
    always @(negedge clk) begin
        if (mon_on) begin
            if (ras_strobe && cas_strobe) check(0, "R9 strobe overlap", 1, 0);
            if (refresh_cycle) begin
                check(dram_addr == 2'(exp_ptr), "R7 refresh row", dram_addr, exp_ptr);
                check(!cas_strobe && ras_strobe, "R8 refresh strobes", cas_strobe, 0);
                exp_ptr = (exp_ptr + 1) % 4;
                rf_period = cyc - rf_last;
                rf_last = cyc;
                rf_n++;
            end else if (ras_strobe) begin
                ras_cnt++;
                check(dram_addr == 2'(cur_row), "R2 row on addr bus", dram_addr, cur_row);
            end
            if (cas_strobe) check(dram_addr == 2'(cur_col), "R3 column on addr bus", dram_addr, cur_col);
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    check(0, "R9 unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rsp_rdata == e.data, {e.tag, " data"}, rsp_rdata, e.data);
                    if (e.lat >= 0) check(cyc - e.acc == e.lat, {e.tag, " latency"}, cyc - e.acc, e.lat);
                    check(ras_cnt - e.ras0 == e.nras, {e.tag, " row strobes"}, ras_cnt - e.ras0, e.nras);
                end
            end
        end
    end

    task automatic access(bit wr, int row, int col, logic [7:0] wd, logic [7:0] exp, int lat, int nras, string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_row = 2'(row); req_col = 2'(col); req_wdata = wd;
        while (!req_ready) @(negedge clk);
        cur_row = row; cur_col = col;
        e.data = exp; e.lat = lat; e.acc = cyc + 1; e.ras0 = ras_cnt; e.nras = nras; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        #1 req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic wait_refresh();
        int n0;
        n0 = rf_n;
        while (rf_n == n0) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check(0, "watchdog", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(!rsp_valid && !ras_strobe && !cas_strobe && !refresh_cycle, "R1 outputs idle", rsp_valid, 0);
        mon_on = 1'b1;
        access(1, 0, 1, 8'hA5, 8'hA5, 2, 1, "R1 R2 cold write");
        access(0, 0, 1, 8'h00, 8'hA5, 1, 0, "R3 R5 hit read");
        access(1, 0, 3, 8'h3C, 8'h3C, 1, 0, "R3 hit write");
        access(0, 0, 1, 8'h00, 8'hA5, 1, 0, "R5 neighbour kept");
        access(0, 2, 0, 8'h00, 8'h00, 3, 1, "R4 conflict read");
        access(1, 2, 2, 8'h7E, 8'h7E, 1, 0, "R3 hit write row2");
        access(0, 0, 3, 8'h00, 8'h3C, 3, 1, "R4 R6 conflict writeback");
        access(1, 0, 2, 8'h5A, 8'h5A, 1, 0, "R3 hit write before refresh");
        // row 0 open: the refresh closes it
        wait_refresh();
        wait_refresh();
        wait_refresh();
        check(rf_period == INTERVAL, "R7 refresh period", rf_period, INTERVAL);
        check(exp_ptr == 3, "R7 pointer advance", exp_ptr, 3);
        access(0, 0, 2, 8'h00, 8'h5A, 2, 1, "R6 R8 reopen after refresh");
        access(0, 2, 2, 8'h00, 8'h7E, 3, 1, "R6 conflict row2 data");
        access(0, 2, 0, 8'h00, 8'h00, 1, 0, "R3 final hit");
        check(sb.size() == 0, "R9 responses drained", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule